// File: doc/BRIEF.md
# Synthesizer Programming Slave (I2C)

This block is the two-wire serial front end of a frequency synthesizer. A fast system clock samples SCL and SDA. Each line passes through a two-flop synchronizer and a glitch filter, and START and STOP conditions are detected on the filtered lines. When the 7-bit address matches one of four selectable addresses, the block acknowledges by holding SDA low. In write mode each data byte lands in one of three registers: the 15-bit divide ratio, a control register for the charge pump and test mode, or a six-bit port register. In read mode the block shifts out a status byte made from a power-on flag, a lock indication, three port input levels and a 3-bit converter code.

The master can write any number of byte pairs after a single address. The first bit of the opening byte of each pair picks the target pair. A byte cut off by STOP or START before its eighth bit changes nothing. The power-on flag stays set from reset until a STOP closes a read sequence, so firmware learns that the settings were lost.

All outputs are plain register pins, and all status inputs are plain levels. The block has no streaming path that would need a valid/ready handshake. The caller builds the open-drain pad by pulling SDA low whenever `sda_oe` is 1.

Top module: `synth_ctl_slave`

## Requirements
- R1: After reset `div_ratio`, `cp_hi`, `test_en`, `pump_off`, `drv_off` and `port_on` are all 0 (all ports high impedance), `sda_oe` is 0 and the power-on flag is 1.
- R2: The slave address is binary 11000 followed by `addr_sel[1:0]`, and the byte's last bit is R/W (1 = read). On a match the block drives `sda_oe` = 1 during the ninth clock. Any other address gets no acknowledge and changes no register.
- R3: A data byte whose first bit (MSB) is 0 opens a frequency pair. Its low 7 bits become `div_ratio[14:8]` when the byte completes. The next byte becomes `div_ratio[7:0]`. The block acknowledges every data byte.
- R4: A data byte whose MSB is 1 opens a control pair. Its bit 6 sets `cp_hi`, bit 5 sets `test_en`, bit 4 sets `pump_off` and bit 0 sets `drv_off`. The next byte's bits 5..0 go to `port_on[5:0]`, where bit 0 is port P2 and bit 5 is port P7, and 1 means the low-impedance (on) state.
- R5: Pairs may follow one another without a new address until a STOP. Each accepted address restarts pairing at an opening byte.
- R6: A byte interrupted by STOP or START before its eighth bit leaves its target register unchanged. Bytes that completed earlier keep their effect.
- R7: A read returns the status byte MSB first as {POR, `lock_i`, `port_lvl_i[2]` (P7), `port_lvl_i[1]` (P5), `port_lvl_i[0]` (P4), `adc_i[2:0]`}. The inputs are captured when the byte's first bit is driven.
- R8: After each status byte, a master acknowledge (SDA low) makes the block send a freshly captured status byte. A master non-acknowledge makes it release SDA until the next START.
- R9: The power-on flag is cleared only by a STOP that ends a sequence containing a read. A STOP after writes leaves it set.
- R10: A pulse on SDA or SCL shorter than `FILT_LEN` system clocks is ignored. It creates no START, STOP or bit.
- R11: `sda_oe` and all register outputs change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Selects one of four slave addresses |
| lock_i | input | 1 | 1 when the loop is locked |
| port_lvl_i | input | 3 | Levels on ports P7, P5, P4 |
| adc_i | input | 3 | Converter code |
| div_ratio | output | 15 | Programmable divide ratio |
| cp_hi | output | 1 | High charge-pump current |
| test_en | output | 1 | Comparator test mode |
| pump_off | output | 1 | Charge pump disabled |
| drv_off | output | 1 | Drive amplifier output off |
| port_on | output | 6 | P2..P7 on (low impedance) when 1 |

## Verification
The bench sweeps every address against every `addr_sel` setting. A decoder that ignored the select bits would acknowledge foreign addresses, and one that was not gated by the match would let a foreign write corrupt `div_ratio`. The bench streams mixed frequency and control pairs after one address, which catches pairing that ignores the opening bit or fails to alternate. It aborts bytes with both STOP and a repeated START to expose early commits. It reads long acknowledged status streams while the inputs change between bytes, which would show stale capture. It also checks that the power-on flag survives write STOPs and falls only after a read, so a design that cleared it on any STOP would report 0 too early. A one-clock SDA dip while SCL is high would end a transfer if the glitch filter were missing.

// File: rtl/syn_pkg.sv
package syn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } link_st_t;

  typedef struct packed {
    logic cp_hi;
    logic test_en;
    logic pump_off;
    logic drv_off;
  } ctrl_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/syn_line_filter.sv
module syn_line_filter #(
  parameter int N        = 2,
  parameter int FILT_LEN = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] filt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          f_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= 2'b11;
        run_q  <= '0;
        f_q    <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw[g]};
        if (sync_q[1] != f_q) begin
          if (run_q == CW'(FILT_LEN - 1)) begin
            f_q   <= sync_q[1];
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          run_q <= '0;
        end
      end
    end
    assign filt[g] = f_q;
  end
endmodule

// File: rtl/syn_link.sv
module syn_link
  import syn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [6:0]        dev_addr,
  input  logic              lock_i,
  input  logic [2:0]        port_lvl_i,
  input  logic [2:0]        adc_i,
  output logic              sda_oe,
  output logic              wr_div_hi,
  output logic              wr_div_lo,
  output logic              wr_ctrl,
  output logic              wr_port,
  output logic [BYTE_W-1:0] wr_byte
);
  link_st_t          st_q;
  logic              scl_d, sda_d;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              rw_q, pair_pos_q, pair_kind_q, rd_seq_q, por_q, mack_q;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic [BYTE_W-1:0] status;

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
  assign status   = {por_q, lock_i, port_lvl_i, adc_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;   scl_d <= 1'b1;     sda_d <= 1'b1;
      cnt_q <= '0;       rx_q <= '0;        tx_q <= '0;
      rw_q <= 1'b0;      pair_pos_q <= 1'b0; pair_kind_q <= 1'b0;
      rd_seq_q <= 1'b0;  por_q <= 1'b1;     mack_q <= 1'b0;
      sda_oe <= 1'b0;
      wr_div_hi <= 1'b0; wr_div_lo <= 1'b0; wr_ctrl <= 1'b0; wr_port <= 1'b0;
      wr_byte <= '0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      wr_div_hi <= 1'b0; wr_div_lo <= 1'b0; wr_ctrl <= 1'b0; wr_port <= 1'b0;
      if (stop_ev) begin
        st_q   <= ST_IDLE;
        sda_oe <= 1'b0;
        if (rd_seq_q) por_q <= 1'b0;
        rd_seq_q <= 1'b0;
      end else if (start_ev) begin
        st_q   <= ST_ADDR;
        cnt_q  <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (rx_q[7:1] == dev_addr) begin
                  sda_oe     <= 1'b1;
                  rw_q       <= rx_q[0];
                  pair_pos_q <= 1'b0;
                  st_q       <= ST_AACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                wr_byte <= rx_q;
                if (!pair_pos_q) begin
                  pair_kind_q <= rx_q[7];
                  wr_div_hi   <= ~rx_q[7];
                  wr_ctrl     <= rx_q[7];
                end else begin
                  wr_div_lo <= ~pair_kind_q;
                  wr_port   <= pair_kind_q;
                end
                pair_pos_q <= ~pair_pos_q;
                sda_oe     <= 1'b1;
                st_q       <= ST_WACK;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (rw_q) begin
              tx_q     <= status;
              sda_oe   <= ~status[7];
              rd_seq_q <= 1'b1;
              st_q     <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st_q   <= ST_WDAT;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st_q   <= ST_WDAT;
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              sda_oe <= 1'b0;
              cnt_q  <= '0;
              st_q   <= ST_RACK;
            end else begin
              tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_q[6];
              cnt_q  <= cnt_q + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_f;
            else if (scl_fall) begin
              if (mack_q) begin
                tx_q   <= status;
                sda_oe <= ~status[7];
                st_q   <= ST_RDAT;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/syn_regs.sv
module syn_regs
  import syn_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int PORT_N = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_div_hi,
  input  logic              wr_div_lo,
  input  logic              wr_ctrl,
  input  logic              wr_port,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [DIV_W-1:0]  div_ratio,
  output ctrl_t             ctrl,
  output logic [PORT_N-1:0] port_on
);
  localparam int HI_W = DIV_W - BYTE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_ratio <= '0;
      ctrl      <= '0;
      port_on   <= '0;
    end else begin
      if (wr_div_hi) div_ratio[DIV_W-1:BYTE_W] <= wr_byte[HI_W-1:0];
      if (wr_div_lo) div_ratio[BYTE_W-1:0]     <= wr_byte;
      if (wr_ctrl) begin
        ctrl.cp_hi    <= wr_byte[6];
        ctrl.test_en  <= wr_byte[5];
        ctrl.pump_off <= wr_byte[4];
        ctrl.drv_off  <= wr_byte[0];
      end
      if (wr_port) port_on <= wr_byte[PORT_N-1:0];
    end
  end
endmodule

// File: rtl/synth_ctl_slave.sv
module synth_ctl_slave
  import syn_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter logic [4:0] ADDR_HI  = 5'b11000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  input  logic        lock_i,
  input  logic [2:0]  port_lvl_i,
  input  logic [2:0]  adc_i,
  output logic [14:0] div_ratio,
  output logic        cp_hi,
  output logic        test_en,
  output logic        pump_off,
  output logic        drv_off,
  output logic [5:0]  port_on
);
  logic [1:0]        lines_f;
  logic              wr_div_hi, wr_div_lo, wr_ctrl, wr_port;
  logic [BYTE_W-1:0] wr_byte;
  ctrl_t             ctrl;

  syn_line_filter #(.N(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}), .filt(lines_f)
  );

  syn_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_f(lines_f[1]), .sda_f(lines_f[0]),
    .dev_addr({ADDR_HI, addr_sel}), .lock_i(lock_i), .port_lvl_i(port_lvl_i),
    .adc_i(adc_i), .sda_oe(sda_oe), .wr_div_hi(wr_div_hi), .wr_div_lo(wr_div_lo),
    .wr_ctrl(wr_ctrl), .wr_port(wr_port), .wr_byte(wr_byte)
  );

  syn_regs #(.DIV_W(15), .PORT_N(6)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_div_hi(wr_div_hi), .wr_div_lo(wr_div_lo),
    .wr_ctrl(wr_ctrl), .wr_port(wr_port), .wr_byte(wr_byte),
    .div_ratio(div_ratio), .ctrl(ctrl), .port_on(port_on)
  );

  assign cp_hi    = ctrl.cp_hi;
  assign test_en  = ctrl.test_en;
  assign pump_off = ctrl.pump_off;
  assign drv_off  = ctrl.drv_off;
endmodule

// File: rtl/syn_ctl_checks.sv
module syn_ctl_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [14:0] div_ratio,
  input logic        cp_hi,
  input logic        pump_off,
  input logic [5:0]  port_on
);
  a_r1_ports_hiz_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (port_on == 6'd0 && div_ratio == 15'd0));

  a_r11_div_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_ratio) |-> !scl_i);

  a_r11_ports_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_on) |-> !scl_i);

  a_r4_ctrl_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cp_hi) || !$stable(pump_off)) |-> !scl_i);

  a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind synth_ctl_slave syn_ctl_checks u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .div_ratio(div_ratio), .cp_hi(cp_hi), .pump_off(pump_off), .port_on(port_on)
);

// File: tb/synth_ctl_slave_tb_top.sv
module synth_ctl_slave_tb_top;
  localparam int HALF = 20;
  localparam int QTR  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0;
  logic [1:0] addr_sel = 2'd0;
  logic lock_i = 1'b0;
  logic [2:0] port_lvl_i = 3'd0, adc_i = 3'd0;
  logic sda_oe, cp_hi, test_en, pump_off, drv_off;
  logic [14:0] div_ratio;
  logic [5:0] port_on;
  logic sda_bus;
  int checks = 0, errors = 0;
  logic exp_por = 1'b1;

  assign sda_bus = m_sda & ~sda_oe & ~glitch;
  always #2 clk = ~clk;

  synth_ctl_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .port_lvl_i(port_lvl_i), .adc_i(adc_i),
    .div_ratio(div_ratio), .cp_hi(cp_hi), .test_en(test_en), .pump_off(pump_off),
    .drv_off(drv_off), .port_on(port_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wt(QTR); m_scl = 1'b1; wt(HALF);
    m_sda = 1'b0; wt(HALF); m_scl = 1'b0; wt(QTR);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wt(QTR); m_scl = 1'b1; wt(HALF);
    m_sda = 1'b1; wt(HALF);
  endtask

  task automatic clk_bit(input logic d, input logic gl, output logic s);
    m_sda = d; wt(QTR); m_scl = 1'b1; wt(QTR / 2);
    if (gl) begin glitch = 1'b1; wt(1); glitch = 1'b0; end
    wt(QTR / 2); s = sda_bus; wt(QTR); m_scl = 1'b0; wt(QTR);
  endtask

  task automatic write_byte(input logic [7:0] b, input logic [7:0] gmask, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], gmask[i], s);
    clk_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 1'b0, s); b[i] = s; end
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] a, input logic rd);
    return {5'b11000, a, rd};
  endfunction

  task automatic write_div(input logic [14:0] v, output logic a2, output logic a3);
    write_byte({1'b0, v[14:8]}, 8'h00, a2);
    write_byte(v[7:0], 8'h00, a3);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic ack, a2, a3;
    logic [7:0] rb;
    logic [14:0] exp_div;
    logic [5:0] exp_port;
    logic [3:0] exp_ctrl;
    wt(5); rst_n = 1'b1; wt(5);

    // R1 reset state
    chk("R1 div", div_ratio, 0);
    chk("R1 port", port_on, 0);
    chk("R1 ctrl", {cp_hi, test_en, pump_off, drv_off}, 0);
    chk("R1 sda_oe", sda_oe, 0);
    exp_div = '0;

    // R2 address sweep: every select against every low address
    for (int sel = 0; sel < 4; sel++) begin
      addr_sel = 2'(sel);
      for (int a = 0; a < 4; a++) begin
        logic [14:0] v;
        v = 15'(sel * 4099 + a * 517 + 3);
        i2c_start();
        write_byte(addr_byte(2'(a), 1'b0), 8'h00, ack);
        chk("R2 ack", ack, (a == sel) ? 1 : 0);
        write_div(v, a2, a3);
        i2c_stop();
        if (a == sel) begin
          exp_div = v;
          chk("R3 data ack", {a2, a3}, 3);
        end
        chk("R2 div after write", div_ratio, exp_div);
      end
    end
    // R2 wrong upper bits
    addr_sel = 2'd1;
    i2c_start();
    write_byte(8'h42, 8'h00, ack);
    chk("R2 foreign upper bits", ack, 0);
    write_div(15'h1234, a2, a3);
    i2c_stop();
    chk("R2 foreign no effect", div_ratio, exp_div);

    // R3 R4 R5 streaming mixed pairs after one address
    i2c_start();
    write_byte(addr_byte(2'd1, 1'b0), 8'h00, ack);
    chk("R5 addr ack", ack, 1);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b4, b5;
      logic [14:0] v;
      v = 15'(k * 2047 + 1) ^ ((k == 15) ? 15'h7fff : 15'h0);
      write_div(v, a2, a3);
      exp_div = v;
      chk("R3 div stream", div_ratio, exp_div);
      b4 = {1'b1, 3'(k), 3'(k * 3), k[3]};
      b5 = 8'(k * 37 + 5);
      write_byte(b4, 8'h00, a2);
      write_byte(b5, 8'h00, a3);
      exp_ctrl = {b4[6], b4[5], b4[4], b4[0]};
      exp_port = b5[5:0];
      chk("R4 ctrl", {cp_hi, test_en, pump_off, drv_off}, exp_ctrl);
      chk("R4 port", port_on, exp_port);
      chk("R5 acks", {a2, a3}, 3);
    end
    i2c_stop();

    // R6 abort mid-byte with STOP: low byte kept, high byte taken
    i2c_start();
    write_byte(addr_byte(2'd1, 1'b0), 8'h00, ack);
    write_byte(8'h2a, 8'h00, a2);
    begin
      logic s;
      for (int i = 0; i < 4; i++) clk_bit(1'b1, 1'b0, s);
    end
    i2c_stop();
    exp_div = {7'h2a, exp_div[7:0]};
    chk("R6 stop abort", div_ratio, exp_div);

    // R6 abort control byte with repeated START
    i2c_start();
    write_byte(addr_byte(2'd1, 1'b0), 8'h00, ack);
    begin
      logic s;
      for (int i = 0; i < 3; i++) clk_bit(i == 0, 1'b0, s);
    end
    i2c_start();
    write_byte(addr_byte(2'd1, 1'b0), 8'h00, ack);
    chk("R6 start abort ctrl", {cp_hi, test_en, pump_off, drv_off}, exp_ctrl);
    // R5 pairing restarted: this byte opens a frequency pair
    write_div(15'h5a5a, a2, a3);
    exp_div = 15'h5a5a;
    chk("R5 restart pairing", div_ratio, exp_div);
    i2c_stop();

    // R10 one-clock SDA dips while SCL high on a 1 bit
    i2c_start();
    write_byte(addr_byte(2'd1, 1'b0), 8'h00, ack);
    write_byte(8'h13, 8'h11, a2);
    write_byte(8'hff, 8'h81, a3);
    i2c_stop();
    exp_div = 15'h13ff;
    chk("R10 glitch ignored", div_ratio, exp_div);

    // R7 R8 R9 long acknowledged read; POR still 1 after write STOPs
    lock_i = 1'b1; port_lvl_i = 3'd5; adc_i = 3'd2;
    i2c_start();
    write_byte(addr_byte(2'd1, 1'b1), 8'h00, ack);
    chk("R7 read addr ack", ack, 1);
    for (int k = 0; k < 8; k++) begin
      logic s;
      logic [7:0] e;
      e = {exp_por, lock_i, port_lvl_i, adc_i};
      read_byte(rb);
      chk("R9 R7 status", rb, e);
      lock_i = k[0]; port_lvl_i = 3'(k * 3); adc_i = 3'(7 - k);
      clk_bit(k == 7, 1'b0, s);
    end
    wt(QTR);
    chk("R8 released after nack", sda_oe, 0);
    i2c_stop();
    exp_por = 1'b0;

    i2c_start();
    write_byte(addr_byte(2'd1, 1'b1), 8'h00, ack);
    read_byte(rb);
    chk("R9 por cleared", rb, {exp_por, lock_i, port_lvl_i, adc_i});
    begin logic s; clk_bit(1'b1, 1'b0, s); end
    i2c_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule